// File: doc/BRIEF.md
# Field Memory Power-Up Initializer

This block drives the two serial ports of a field-memory device from power-on to a defined pointer state. The device's address pointers are undefined at power-on. The block waits a fixed stabilisation time once power-good is reported. It then clocks both ports through a run of dummy cycles, issues a reset strobe on each port, and after that signals ready. The system logic hands the ports over to normal traffic only after ready.

Each port gets a clock that runs at half the system clock rate, along with an enable and a reset strobe. The enable and the strobe change only on the system edge where the port clock falls, so they are stable around every rising edge of the port clock. The write port and the read port run the same sequence at the same time.

A retry request starts a recovery run. This is for the case where the supply may have been unstable while the dummy cycles ran. The recovery run waits the settle time again and then brackets the dummy cycles between two reset strobes. Losing power-good aborts any run at once.

Top module: `fmem_pwrup_init`

## Requirements
- R1: While rst_n is low, every output (port clocks, enables, reset strobes, ready) is low.
- R2: While pwr_good is low, no port clock rises, no strobe or enable is high and ready is low; retry has no effect in that condition.
- R3: Counting the system edge that first samples pwr_good high as edge 1, the first port clock rise is at edge SETTLE_CYC+2.
- R4: In a normal run, exactly DUMMY_N port clock rises occur with enable high and strobe low before the reset strobe.
- R5: A reset strobe is high for exactly one port clock rise, with enable low. The write and read ports carry identical clock, enable and strobe.
- R6: Each strobe is followed by GAP_N (at least 2) port clock rises with strobe and enable low. A strobe is never given with fewer than two low-strobe rises before it.
- R7: In a normal run, ready rises at edge SETTLE_CYC + 2·DUMMY_N + 2·GAP_N + 3. While ready is high, all port clocks, enables and strobes stay low.
- R8: When retry is sampled with pwr_good high, ready is low after that edge and the settle wait restarts. The port rises then follow this order: gap, strobe, gap, DUMMY_N dummy rises, strobe, gap. Ready rises at edge SETTLE_CYC + 2·DUMMY_N + 6·GAP_N + 5, counted from the edge that sampled retry.
- R9: When pwr_good is sampled low, all outputs are low after that edge, and recovery mode is cleared. The next time pwr_good is high, a normal run starts.
- R10: Enable and strobe never change on a system edge where a port clock rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_good | input | 1 | Supply stable indication |
| retry | input | 1 | Request for the recovery sequence |
| wr_clk_o | output | 1 | Write-port clock |
| wr_rst_o | output | 1 | Write-port pointer reset strobe |
| wr_en_o | output | 1 | Write-port enable |
| rd_clk_o | output | 1 | Read-port clock |
| rd_rst_o | output | 1 | Read-port pointer reset strobe |
| rd_en_o | output | 1 | Read-port enable |
| ready_o | output | 1 | Initialization complete |

## Verification
Every timed result is counted in system edges, starting with the edge that samples the stimulus as edge 1. The first port clock rise is due at SETTLE_CYC+2. Ready is due at SETTLE_CYC+2·DUMMY_N+2·GAP_N+3 for a normal run, or at SETTLE_CYC+2·DUMMY_N+6·GAP_N+5 for a recovery run. An abort takes effect one edge after it is sampled. The bench drives on falling edges, counts rising edges, and samples on the following falling edge, so each value is read in the cycle after the register that produces it has updated. A scoreboard queue holds one expected enable/strobe pair for each port clock rise. It is popped whenever a rise appears, which checks both the order and the exact number of rises in each phase.

// File: rtl/fpi_pkg.sv
package fpi_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETTLE,
    ST_DUMMY,
    ST_RESET,
    ST_GAP,
    ST_READY
  } seq_st_e;

  // states in which the port clock toggles
  function automatic logic is_running(seq_st_e s);
    return (s == ST_DUMMY) || (s == ST_RESET) || (s == ST_GAP);
  endfunction

  // where a finished gap leads; step counts gaps already left in this run
  function automatic seq_st_e gap_exit(logic recov, logic [1:0] step);
    if (!recov) return ST_READY;
    case (step)
      2'd0:    return ST_RESET;
      2'd1:    return ST_DUMMY;
      default: return ST_READY;
    endcase
  endfunction

  // system edge (sampling edge = 1) on which ready rises, normal run
  function automatic int unsigned normal_edges(int unsigned s, int unsigned d,
                                               int unsigned g);
    return s + 2 * d + 2 * g + 3;
  endfunction

  // same for a recovery run, counted from the edge that sampled retry
  function automatic int unsigned recovery_edges(int unsigned s, int unsigned d,
                                                 int unsigned g);
    return s + 2 * d + 6 * g + 5;
  endfunction

endpackage

// File: rtl/fpi_settle_timer.sv
module fpi_settle_timer #(
  parameter int unsigned SETTLE_CYC = 12_500_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hold,
  output logic done
);
  localparam int unsigned TW = (SETTLE_CYC > 1) ? $clog2(SETTLE_CYC) : 1;
  localparam logic [TW-1:0] T_LAST = TW'(SETTLE_CYC - 1);

  logic [TW-1:0] tmr;

  assign done = !hold && (tmr == T_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            tmr <= '0;
    else if (hold || done) tmr <= '0;
    else                   tmr <= tmr + TW'(1);
  end

  // the wait counter never runs past its terminal value (R3)
  assert_settle_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    tmr <= T_LAST);

endmodule

// File: rtl/fpi_edge_cnt.sv
module fpi_edge_cnt #(
  parameter int unsigned MAXN = 80,
  localparam int unsigned CW = $clog2(MAXN + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          fall,
  input  logic [CW-1:0] limit,
  output logic          last
);
  logic [CW-1:0] cnt;

  assign last = fall && (cnt == limit - CW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt <= '0;
    else if (clr || last)  cnt <= '0;
    else if (fall)         cnt <= cnt + CW'(1);
  end

  // a phase never counts beyond its limit (R4)
  assert_phase_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |-> cnt < limit);

endmodule

// File: rtl/fpi_seq.sv
module fpi_seq
  import fpi_pkg::*;
#(
  parameter int unsigned SETTLE_CYC = 12_500_000,
  parameter int unsigned DUMMY_N    = 80,
  parameter int unsigned GAP_N      = 2
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    pwr_good,
  input  logic    retry,
  output seq_st_e state_o,
  output logic    pclk_o
);
  localparam int unsigned MAXN = (DUMMY_N > GAP_N) ? DUMMY_N : GAP_N;
  localparam int unsigned CW   = $clog2(MAXN + 1);
  localparam logic [CW-1:0] D_LIM = CW'(DUMMY_N);
  localparam logic [CW-1:0] G_LIM = CW'(GAP_N);
  localparam logic [CW-1:0] R_LIM = CW'(1);
  localparam logic [31:0] NORM_EDGES = 32'(normal_edges(SETTLE_CYC, DUMMY_N, GAP_N));
  localparam logic [31:0] REC_EDGES  = 32'(recovery_edges(SETTLE_CYC, DUMMY_N, GAP_N));

  seq_st_e       state, state_nx;
  logic          pclk;
  logic          recov, recov_nx;
  logic [1:0]    step, step_nx;
  logic          abort;
  logic          run;
  logic          fall;
  logic          settle_hold;
  logic          settle_done;
  logic          phase_last;
  logic [CW-1:0] limit;

  assign abort       = !pwr_good || retry;
  assign run         = is_running(state);
  assign fall        = run && pclk;
  assign settle_hold = (state != ST_SETTLE) || abort;

  always_comb begin
    case (state)
      ST_DUMMY: limit = D_LIM;
      ST_RESET: limit = R_LIM;
      default:  limit = G_LIM;
    endcase
  end

  fpi_settle_timer #(.SETTLE_CYC(SETTLE_CYC)) u_settle (
    .clk   (clk),
    .rst_n (rst_n),
    .hold  (settle_hold),
    .done  (settle_done)
  );

  fpi_edge_cnt #(.MAXN(MAXN)) u_phase (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (!run),
    .fall  (fall),
    .limit (limit),
    .last  (phase_last)
  );

  always_comb begin
    state_nx = state;
    recov_nx = recov;
    step_nx  = step;
    if (!pwr_good) begin
      state_nx = ST_IDLE;
      recov_nx = 1'b0;
      step_nx  = 2'd0;
    end else if (retry) begin
      state_nx = ST_SETTLE;
      recov_nx = 1'b1;
      step_nx  = 2'd0;
    end else begin
      case (state)
        ST_IDLE:   state_nx = ST_SETTLE;
        ST_SETTLE: if (settle_done) state_nx = recov ? ST_GAP : ST_DUMMY;
        ST_DUMMY:  if (phase_last) state_nx = ST_RESET;
        ST_RESET:  if (phase_last) state_nx = ST_GAP;
        ST_GAP: begin
          if (phase_last) begin
            state_nx = gap_exit(recov, step);
            step_nx  = step + 2'd1;
          end
        end
        default:   state_nx = state;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      pclk  <= 1'b0;
      recov <= 1'b0;
      step  <= 2'd0;
    end else begin
      state <= state_nx;
      pclk  <= (run && !abort) ? !pclk : 1'b0;
      recov <= recov_nx;
      step  <= step_nx;
    end
  end

  assign state_o = state;
  assign pclk_o  = pclk;

  // checker: system edges since the run started
  logic [31:0] since_start;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                            since_start <= 32'd0;
    else if (abort || state == ST_IDLE)    since_start <= 32'd1;
    else if (state != ST_READY)            since_start <= since_start + 32'd1;
  end

  assert_ready_time_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(state == ST_READY) && !recov) |-> since_start == NORM_EDGES);

  assert_ready_time_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(state == ST_READY) && recov) |-> since_start == REC_EDGES);

  assert_retry_restart_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_good && retry) |=> (state == ST_SETTLE && !pclk));

  assert_power_loss_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_good |=> (state == ST_IDLE && !pclk && !recov));

endmodule

// File: rtl/fpi_port_drv.sv
module fpi_port_drv
  import fpi_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  seq_st_e state,
  input  logic    pclk,
  output logic    clk_o,
  output logic    en_o,
  output logic    rst_o
);
  assign clk_o = pclk;
  assign en_o  = (state == ST_DUMMY);
  assign rst_o = (state == ST_RESET);

  // checker: port clock rises seen with the strobe low, saturating at 3
  logic       clk_q;
  logic [1:0] low_rises;
  logic       rise;
  assign rise = clk_o && !clk_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clk_q     <= 1'b0;
      low_rises <= 2'd0;
    end else begin
      clk_q <= clk_o;
      if (rise) begin
        if (rst_o)                   low_rises <= 2'd0;
        else if (low_rises != 2'd3)  low_rises <= low_rises + 2'd1;
      end
    end
  end

  assert_rst_gap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rise && rst_o) |-> low_rises >= 2'd2);

  assert_rst_no_en_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rst_o |-> !en_o);

  assert_ctl_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(clk_o) |-> ($stable(en_o) && $stable(rst_o)));

endmodule

// File: rtl/fmem_pwrup_init.sv
module fmem_pwrup_init
  import fpi_pkg::*;
#(
  parameter int unsigned SETTLE_CYC = 12_500_000,
  parameter int unsigned DUMMY_N    = 80,
  parameter int unsigned GAP_N      = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pwr_good,
  input  logic retry,
  output logic wr_clk_o,
  output logic wr_rst_o,
  output logic wr_en_o,
  output logic rd_clk_o,
  output logic rd_rst_o,
  output logic rd_en_o,
  output logic ready_o
);
  localparam int unsigned NPORT = 2;

  seq_st_e          state;
  logic             pclk;
  logic [NPORT-1:0] clk_v, en_v, rst_v;

  fpi_seq #(
    .SETTLE_CYC (SETTLE_CYC),
    .DUMMY_N    (DUMMY_N),
    .GAP_N      (GAP_N)
  ) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .pwr_good (pwr_good),
    .retry    (retry),
    .state_o  (state),
    .pclk_o   (pclk)
  );

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    fpi_port_drv u_drv (
      .clk   (clk),
      .rst_n (rst_n),
      .state (state),
      .pclk  (pclk),
      .clk_o (clk_v[p]),
      .en_o  (en_v[p]),
      .rst_o (rst_v[p])
    );
  end

  assign wr_clk_o = clk_v[0];
  assign wr_en_o  = en_v[0];
  assign wr_rst_o = rst_v[0];
  assign rd_clk_o = clk_v[1];
  assign rd_en_o  = en_v[1];
  assign rd_rst_o = rst_v[1];
  assign ready_o  = (state == ST_READY);

  assert_ready_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ready_o |-> (clk_v == '0 && en_v == '0 && rst_v == '0));

  assert_no_power_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_good |=> (!ready_o && clk_v == '0 && en_v == '0 && rst_v == '0));

endmodule

// File: tb/sim_fmem_pwrup_init.sv
module sim_fmem_pwrup_init;
  localparam int S = 20;
  localparam int D = 80;
  localparam int G = 2;
  localparam int NORM_READY = 1 + S + 2 * D + 2 + 2 * G;           // settle, dummy, strobe, gap
  localparam int REC_READY  = 1 + S + 3 * (2 * G) + 2 * 2 + 2 * D; // three gaps, two strobes

  logic clk = 1'b0;
  logic rst_n, pwr_good, retry;
  logic wr_clk_o, wr_rst_o, wr_en_o, rd_clk_o, rd_rst_o, rd_en_o, ready_o;

  always #4 clk = ~clk;  // 125 MHz

  fmem_pwrup_init #(.SETTLE_CYC(S), .DUMMY_N(D), .GAP_N(G)) u0 (
    .clk(clk), .rst_n(rst_n), .pwr_good(pwr_good), .retry(retry),
    .wr_clk_o(wr_clk_o), .wr_rst_o(wr_rst_o), .wr_en_o(wr_en_o),
    .rd_clk_o(rd_clk_o), .rd_rst_o(rd_rst_o), .rd_en_o(rd_en_o),
    .ready_o(ready_o)
  );

  int checks = 0;
  int errors = 0;

  typedef struct { bit en; bit rs; string req; } exp_t;
  exp_t sb[$];

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int quiet_vec();
    return {wr_clk_o, wr_rst_o, wr_en_o, rd_clk_o, rd_rst_o, rd_en_o, ready_o};
  endfunction

  task automatic push(input int n, input bit en, input bit rs, input string req);
    for (int i = 0; i < n; i++) begin
      exp_t e;
      e.en = en; e.rs = rs; e.req = req;
      sb.push_back(e);
    end
  endtask

  task automatic push_normal();
    push(D, 1'b1, 1'b0, "R4");
    push(1, 1'b0, 1'b1, "R5");
    push(G, 1'b0, 1'b0, "R6");
  endtask

  task automatic push_recovery();
    push(G, 1'b0, 1'b0, "R8");
    push(1, 1'b0, 1'b1, "R8");
    push(G, 1'b0, 1'b0, "R6");
    push(D, 1'b1, 1'b0, "R8");
    push(1, 1'b0, 1'b1, "R5");
    push(G, 1'b0, 1'b0, "R6");
  endtask

  // monitor: pop one expected item on each observed port clock rise
  logic prev_w = 1'b0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (wr_clk_o && !prev_w) begin
        if (sb.size() == 0) begin
          chk(1'b0, "R2", "unexpected port clock rise", 1, 0);
        end else begin
          exp_t e;
          e = sb.pop_front();
          chk(wr_en_o == e.en && wr_rst_o == e.rs, e.req, "write en/strobe at rise",
              {wr_en_o, wr_rst_o}, {e.en, e.rs});
          chk(rd_clk_o && rd_en_o == e.en && rd_rst_o == e.rs, "R5",
              "read port matches write port", {rd_clk_o, rd_en_o, rd_rst_o},
              {1'b1, e.en, e.rs});
        end
      end
    end
    prev_w = wr_clk_o;
  end

  // R10: enable/strobe hold across each rising edge of the port clock
  logic       chg_en_q, chg_rs_q;
  always @(posedge clk) begin
    chg_en_q <= wr_en_o;
    chg_rs_q <= wr_rst_o;
  end
  always @(negedge clk) begin
    if (rst_n && wr_clk_o && !prev_w)
      if (wr_en_o != chg_en_q || wr_rst_o != chg_rs_q)
        chk(1'b0, "R10", "control changed at port rise", {wr_en_o, wr_rst_o},
            {chg_en_q, chg_rs_q});
  end

  // count edges from the one sampling the stimulus (edge 1) to ready
  task automatic run_to_ready(output int first_rise, output int ready_edge);
    int n = 0;
    first_rise = -1;
    ready_edge = -1;
    while (n < 5000) begin
      @(posedge clk);
      n++;
      @(negedge clk);
      retry = 1'b0;
      if (n == 1) chk(ready_o == 1'b0, "R8", "ready low after sampling edge", ready_o, 0);
      if (first_rise < 0 && wr_clk_o) first_rise = n;
      if (ready_o) begin
        ready_edge = n;
        break;
      end
    end
  endtask

  int watchdog = 0;
  bit done_flag = 1'b0;
  always @(posedge clk) begin
    watchdog++;
    if (watchdog > 100000 && !done_flag) begin
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", watchdog, 100000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int fr, re;
    rst_n = 1'b0; pwr_good = 1'b0; retry = 1'b0;
    repeat (3) @(negedge clk);
    chk(quiet_vec() == 0, "R1", "outputs during reset", quiet_vec(), 0);
    rst_n = 1'b1;

    // R2: no power, retry pulse ignored
    for (int i = 0; i < 8; i++) begin
      retry = (i == 2);
      @(negedge clk);
      chk(quiet_vec() == 0, "R2", "outputs with power low", quiet_vec(), 0);
    end
    retry = 1'b0;

    // normal run: R3, R4, R7
    push_normal();
    pwr_good = 1'b1;
    run_to_ready(fr, re);
    chk(fr == S + 2, "R3", "first port rise edge", fr, S + 2);
    chk(re == NORM_READY, "R7", "ready edge normal", re, NORM_READY);
    chk(sb.size() == 0, "R4", "expected rises left", sb.size(), 0);

    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      chk(quiet_vec() == 1, "R7", "quiet while ready", quiet_vec(), 1);
    end

    // recovery run from ready: R8
    retry = 1'b1;
    push_recovery();
    run_to_ready(fr, re);
    chk(re == REC_READY, "R8", "ready edge recovery", re, REC_READY);
    chk(sb.size() == 0, "R8", "expected rises left", sb.size(), 0);

    // recovery aborted by power loss mid-dummy, then a normal run: R9
    retry = 1'b1;
    push_recovery();
    @(negedge clk);
    retry = 1'b0;
    while (!wr_en_o) @(negedge clk);
    repeat (6) @(negedge clk);
    while (wr_clk_o) @(negedge clk);
    pwr_good = 1'b0;
    sb.delete();
    @(negedge clk);
    chk(quiet_vec() == 0, "R9", "outputs after power loss", quiet_vec(), 0);
    repeat (4) @(negedge clk);
    push_normal();
    pwr_good = 1'b1;
    run_to_ready(fr, re);
    chk(re == NORM_READY, "R9", "normal run after power loss", re, NORM_READY);
    chk(sb.size() == 0, "R9", "expected rises left", sb.size(), 0);

    // retry during a reset strobe: gap kept before the next strobe (R6, R8)
    pwr_good = 1'b0;
    @(negedge clk);
    push_normal();
    pwr_good = 1'b1;
    while (!wr_rst_o) @(negedge clk);
    sb.delete();
    retry = 1'b1;
    push_recovery();
    run_to_ready(fr, re);
    chk(re == REC_READY, "R8", "ready edge after strobe retry", re, REC_READY);
    chk(sb.size() == 0, "R6", "expected rises left", sb.size(), 0);

    done_flag = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule